// File: doc/BRIEF.md
# Front-Panel Program Loader

This block is the hand-entry front panel of a small stored-program CPU. A user sets a mode switch, a 4-bit address and an 8-bit data byte, then operates a single strobe switch. The strobe is brought into the clock domain by a synchronizer, and each rising edge becomes one single-cycle command. The synchronized mode decides what that command means. In PROGRAM mode it is a RAM write of the panel byte at the panel address. In RUN mode it is a restart pulse that clears the CPU's program counter and registers but leaves RAM untouched.

While the synchronized mode is PROGRAM, a hold output keeps the CPU sequencer stopped so it cannot drive RAM during hand entry. The address and data presented to RAM are captured on the cycle of the write and kept until the next write. The restart pulse is one cycle long, and the CPU resumes from address 0 when it ends. An active-low asynchronous reset clears every register in the block in either mode.

Top module: `panel_loader`

## Requirements
- R1: While and directly after reset, ram_we_o, cpu_restart_o and cpu_hold_o are 0 and ram_addr_o and ram_data_o are all zeros.
- R2: In PROGRAM mode (mode_i = 1), a rising strobe_i driven just after a clock edge gives ram_we_o high for exactly one cycle, visible after the third following rising clock edge.
- R3: ram_addr_o and ram_data_o take the values of addr_i and data_i when ram_we_o rises. They then stay unchanged until the next write, whatever addr_i and data_i do.
- R4: In RUN mode (mode_i = 0), a rising strobe_i gives cpu_restart_o high for exactly one cycle, after the same three-edge latency as R2.
- R5: A strobe in PROGRAM mode never raises cpu_restart_o. A strobe in RUN mode never raises ram_we_o and leaves ram_addr_o and ram_data_o unchanged.
- R6: A strobe held high for many cycles gives only one pulse, and its falling edge gives none.
- R7: cpu_hold_o equals the mode after a two-flop synchronizer. It is 1 in PROGRAM mode and 0 in RUN mode, and follows a mode change after the second rising clock edge.
- R8: Asserting rst_n low clears all outputs at once, without waiting for a clock edge.
- R9: ram_we_o and cpu_restart_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Panel mode switch: 0 RUN, 1 PROGRAM |
| addr_i | input | 4 | Panel address switches |
| data_i | input | 8 | Panel data switches |
| strobe_i | input | 1 | Shared write / restart switch, asynchronous |
| ram_we_o | output | 1 | Single-cycle RAM write enable |
| ram_addr_o | output | 4 | Captured RAM write address |
| ram_data_o | output | 8 | Captured RAM write data |
| cpu_restart_o | output | 1 | Single-cycle CPU restart pulse |
| cpu_hold_o | output | 1 | Holds the CPU sequencer while in PROGRAM mode |

## Verification
A stuck or missing edge-detector state shows at the ports within four cycles of a strobe change, as a second pulse, a repeated pulse or no pulse at all. A wrong mode routing shows in the same cycle as the pulse, because the pulse appears on the wrong output. A capture register that loads at the wrong time alters ram_addr_o or ram_data_o while ram_we_o is low, and the bench sees this on the next sample. A synchronizer with the wrong depth moves cpu_hold_o and the pulses by one cycle, and the exact-cycle checks catch that.

// File: rtl/panel_pkg.sv
package panel_pkg;

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_PROG = 1'b1
  } panel_mode_e;

  typedef struct packed {
    logic we;
    logic restart;
  } panel_cmd_t;

  function automatic logic f_rise(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic panel_cmd_t f_route(input panel_mode_e mode, input logic edge_evt);
    panel_cmd_t c;
    c.we      = edge_evt && (mode == MODE_PROG);
    c.restart = edge_evt && (mode == MODE_RUN);
    return c;
  endfunction

endpackage

// File: rtl/panel_sync.sv
module panel_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/panel_edge.sv
module panel_edge
  import panel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = f_rise(level_i, prev_q);

endmodule

// File: rtl/panel_route.sv
module panel_route
  import panel_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  panel_mode_e       mode_i,
  input  logic              rise_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              we_o,
  output logic              restart_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  panel_cmd_t cmd;

  assign cmd = f_route(mode_i, rise_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_o      <= 1'b0;
      restart_o <= 1'b0;
      addr_o    <= '0;
      data_o    <= '0;
    end else begin
      we_o      <= cmd.we;
      restart_o <= cmd.restart;
      if (cmd.we) begin
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end
  end

endmodule

// File: rtl/panel_loader.sv
module panel_loader
  import panel_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              strobe_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_data_o,
  output logic              cpu_restart_o,
  output logic              cpu_hold_o
);

  logic        strobe_sync;
  logic        mode_sync;
  logic        rise_evt;
  logic        mode_prog;
  panel_mode_e mode_e;

  panel_sync #(.W(1), .STAGES(SYNC_STAGES)) u_strobe_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (strobe_i),
    .q_o  (strobe_sync)
  );

  panel_sync #(.W(1), .STAGES(SYNC_STAGES)) u_mode_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (mode_i),
    .q_o  (mode_sync)
  );

  panel_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .level_i(strobe_sync),
    .rise_o (rise_evt)
  );

  assign mode_e    = mode_sync ? MODE_PROG : MODE_RUN;
  assign mode_prog = (mode_e == MODE_PROG);

  panel_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_e),
    .rise_i   (rise_evt),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .we_o     (ram_we_o),
    .restart_o(cpu_restart_o),
    .addr_o   (ram_addr_o),
    .data_o   (ram_data_o)
  );

  assign cpu_hold_o = mode_prog;

endmodule

// File: rtl/panel_loader_chk.sv
module panel_loader_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rise_evt,
  input logic              mode_prog,
  input logic              ram_we_o,
  input logic              cpu_restart_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic [DATA_W-1:0] ram_data_o
);

  p_we_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |=> !ram_we_o);

  p_restart_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_restart_o |=> !cpu_restart_o);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ram_addr_o) |-> ram_we_o);

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ram_data_o) |-> ram_we_o);

  p_route_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && mode_prog) |=> (ram_we_o && !cpu_restart_o));

  p_route_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && !mode_prog) |=> (cpu_restart_o && !ram_we_o));

  p_one_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !rise_evt);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we_o && cpu_restart_o));

endmodule

bind panel_loader panel_loader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rise_evt     (rise_evt),
  .mode_prog    (mode_prog),
  .ram_we_o     (ram_we_o),
  .cpu_restart_o(cpu_restart_o),
  .ram_addr_o   (ram_addr_o),
  .ram_data_o   (ram_data_o)
);

// File: tb/panel_loader_tb.sv
module panel_loader_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic       strobe_i = 1'b0;
  logic       ram_we_o, cpu_restart_o, cpu_hold_o;
  logic [3:0] ram_addr_o;
  logic [7:0] ram_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  panel_loader u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .addr_i       (addr_i),
    .data_i       (data_i),
    .strobe_i     (strobe_i),
    .ram_we_o     (ram_we_o),
    .ram_addr_o   (ram_addr_o),
    .ram_data_o   (ram_data_o),
    .cpu_restart_o(cpu_restart_o),
    .cpu_hold_o   (cpu_hold_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    mode_i = m;
    repeat (4) @(negedge clk);
  endtask

  // R1: reset state
  task automatic t_reset;
    check(ram_we_o == 0 && cpu_restart_o == 0 && cpu_hold_o == 0, "R1 ctl",
          {ram_we_o, cpu_restart_o, cpu_hold_o}, 0);
    check(ram_addr_o == 0 && ram_data_o == 0, "R1 bus", {ram_addr_o, ram_data_o}, 0);
  endtask

  // R2 R3 R5 R6: one write in PROGRAM mode
  task automatic t_write(input logic [3:0] a, input logic [7:0] d, input int hold_cycles);
    int we_cnt = 0, rs_cnt = 0, we_at = 0;
    @(negedge clk);
    addr_i = a; data_i = d;
    repeat (2) @(negedge clk);
    strobe_i = 1'b1;
    for (int i = 1; i <= hold_cycles; i++) begin
      @(negedge clk);
      if (ram_we_o) begin we_cnt++; we_at = i; end
      if (cpu_restart_o) rs_cnt++;
      if (i == 3) check(ram_addr_o == a && ram_data_o == d, "R3 capture",
                        {ram_addr_o, ram_data_o}, {a, d});
    end
    check(we_cnt == 1 && we_at == 3, "R2 R6 single write at edge 3", we_cnt * 16 + we_at, 16 + 3);
    check(rs_cnt == 0, "R5 no restart in PROGRAM", rs_cnt, 0);
    strobe_i = 1'b0;
    addr_i = ~a; data_i = ~d;
    we_cnt = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (ram_we_o) we_cnt++;
    end
    check(we_cnt == 0, "R6 falling edge no pulse", we_cnt, 0);
    check(ram_addr_o == a && ram_data_o == d, "R3 held", {ram_addr_o, ram_data_o}, {a, d});
  endtask

  // R4 R5: restart in RUN mode
  task automatic t_restart(input logic [3:0] a_prev, input logic [7:0] d_prev);
    int rs_cnt = 0, rs_at = 0, we_cnt = 0;
    @(negedge clk);
    addr_i = 4'h9; data_i = 8'h77;
    strobe_i = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (cpu_restart_o) begin rs_cnt++; rs_at = i; end
      if (ram_we_o) we_cnt++;
    end
    strobe_i = 1'b0;
    repeat (4) @(negedge clk);
    check(rs_cnt == 1 && rs_at == 3, "R4 single restart at edge 3", rs_cnt * 16 + rs_at, 16 + 3);
    check(we_cnt == 0, "R5 no write in RUN", we_cnt, 0);
    check(ram_addr_o == a_prev && ram_data_o == d_prev, "R5 bus untouched in RUN",
          {ram_addr_o, ram_data_o}, {a_prev, d_prev});
  endtask

  // R7: hold follows synchronized mode
  task automatic t_hold;
    @(negedge clk);
    mode_i = 1'b1;
    @(negedge clk);
    check(cpu_hold_o == 0, "R7 hold after edge 1", cpu_hold_o, 0);
    @(negedge clk);
    check(cpu_hold_o == 1, "R7 hold after edge 2", cpu_hold_o, 1);
    mode_i = 1'b0;
    @(negedge clk);
    check(cpu_hold_o == 1, "R7 release after edge 1", cpu_hold_o, 1);
    @(negedge clk);
    check(cpu_hold_o == 0, "R7 release after edge 2", cpu_hold_o, 0);
  endtask

  // R8: asynchronous reset while the write pulse is high
  task automatic t_async_reset;
    set_mode(1'b1);
    addr_i = 4'hC; data_i = 8'h5A;
    repeat (2) @(negedge clk);
    strobe_i = 1'b1;
    repeat (3) @(negedge clk);
    check(ram_we_o == 1, "R8 pulse before reset", ram_we_o, 1);
    #1 rst_n = 1'b0;
    #1;
    check(ram_we_o == 0 && cpu_hold_o == 0 && ram_addr_o == 0 && ram_data_o == 0,
          "R8 async clear", {ram_we_o, cpu_hold_o, ram_addr_o, ram_data_o}, 0);
    strobe_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold();
    set_mode(1'b1);
    check(cpu_hold_o == 1, "R7 hold in PROGRAM", cpu_hold_o, 1);
    t_write(4'h0, 8'hA5, 6);
    t_write(4'hF, 8'h3C, 12);
    t_write(4'h7, 8'h00, 4);
    set_mode(1'b0);
    check(cpu_hold_o == 0, "R7 hold in RUN", cpu_hold_o, 0);
    t_restart(4'h7, 8'h00);
    t_async_reset();
    set_mode(1'b1);
    t_write(4'h3, 8'hE1, 6);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule